// File: doc/BRIEF.md
# Three-Decade Latched Scanning Counter

A three-digit decimal event counter with a snapshot register and a time-shared digit output. Events arrive as edges on two asynchronous inputs: a count line and a hold line. Either a falling count edge while hold is low, or a rising hold edge while count is high, advances a chain of three BCD decades. A rising edge on the snapshot input copies the live decades into a holding register. Only the held digits are ever shown.

The held digits leave the block one at a time on a shared 4-bit BCD bus. Three active-low select lines name the digit currently on the bus. The scan steps on a tick from an internal divider of the system clock. When the external-scan mode is chosen, it steps instead on rising edges of an external scan clock. Each step is also reported on a scan output, so that further counters can follow the same scan. A carry output lets a further stage count thousands. An active-high clear zeroes the block and blanks all selects while it is held.

Top module: `tri_decade_scan_counter`

## Requirements
- R1: Each of the three decades holds a BCD value from 0 to 9. A decade that advances from 9 returns to 0 and advances the next more significant decade, so the chain counts 000 to 999 and then returns to 000.
- R2: A falling edge of `count_in` while `count_hold` is low advances the count by one. A rising edge of `count_in` has no effect. A falling edge of `count_in` while `count_hold` is high has no effect.
- R3: A rising edge of `count_hold` while `count_in` is high advances the count by one. A rising edge of `count_hold` while `count_in` is low has no effect. A falling edge of `count_hold` has no effect.
- R4: A rising edge of `snap` copies all three live decades into the holding register. The `bcd` output shows only held values, so later advances without a new snapshot do not change what is shown.
- R5: Outside clear, exactly one bit of `dsel_n` is low, and `bcd` carries that digit. Bit 0 selects the hundreds digit (most significant), bit 1 the tens and bit 2 the units.
- R6: The scan order is hundreds, tens, units, and then it repeats. After clear is released the scan starts on hundreds (`dsel_n` = 3'b110).
- R7: With `scan_sel` low, the scan advances once every SCAN_DIV system clocks.
- R8: With `scan_sel` high, the scan advances once on each rising edge of `scan_clk`, and the internal divider has no effect on it.
- R9: `scan_out` is high for exactly the one clock in which the scan position changes, and for no other clock.
- R10: While `clr` is high, all three `dsel_n` bits are high and both the decades and the holding register are zero. After release the held value read back is 000.
- R11: `carry_out` pulses high for one clock each time the count wraps from 999 to 000, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr | input | 1 | Active-high asynchronous clear; blanks the selects |
| count_in | input | 1 | Count input; a falling edge advances the count while hold is low |
| count_hold | input | 1 | Hold input; a rising edge advances the count while count_in is high |
| snap | input | 1 | Rising edge copies the live count into the holding register |
| scan_sel | input | 1 | 1 = scan follows scan_clk, 0 = internal divider |
| scan_clk | input | 1 | External scan clock, synchronised inside the block |
| bcd | output | 4 | Held digit currently selected, active-high BCD |
| dsel_n | output | NUM_DIGITS | Active-low digit selects, bit 0 = most significant |
| carry_out | output | 1 | One-clock pulse on the 999 to 000 wrap |
| scan_out | output | 1 | One-clock pulse on every scan step, for chaining |

## Verification
The assertions assume that `clr` is high from time zero, and that each asynchronous input stays level for at least two system clocks between edges so that the two-flop synchronisers see every edge. They also assume that `count_hold` and `count_in` are not both high at the moment `clr` is released, because an input that is already high at release reads as a rising edge. The stimulus moves inputs only on falling clock edges. It holds every level for four clocks or more, and it releases clear with all inputs low. The hold-line sequences are ordered so that the only hold edges that occur while `count_in` is high are the ones meant to advance the count.

// File: rtl/tdsc_pkg.sv
`timescale 1ns/1ps
package tdsc_pkg;
    typedef logic [3:0] bcd_t;
    localparam bcd_t BCD_TOP = 4'd9;
endpackage

// File: rtl/tdsc_edge_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser with one extra stage for edge detection.
module tdsc_edge_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
        logic [WIDTH-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = async_in;
        sync_d.stable = sync_q.meta;
        sync_d.prev   = sync_q.stable;
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) sync_q <= '0;
        else     sync_q <= sync_d;
    end

    assign level = sync_q.stable;
    assign rise  = sync_q.stable & ~sync_q.prev;
    assign fall  = ~sync_q.stable & sync_q.prev;
endmodule

// File: rtl/tdsc_decade_chain.sv
`timescale 1ns/1ps
// Cascaded BCD decades; index 0 is the least significant digit.
module tdsc_decade_chain
    import tdsc_pkg::*;
#(
    parameter int NUM_DIGITS = 3
) (
    input  logic                  clk,
    input  logic                  clr,
    input  logic                  advance,
    output bcd_t [NUM_DIGITS-1:0] digits,
    output logic                  wrap_pulse
);
    typedef struct packed {
        bcd_t [NUM_DIGITS-1:0] dig;
        logic                  wrap;
    } chain_t;

    chain_t chain_d, chain_q;
    logic   ripple;

    always_comb begin
        chain_d      = chain_q;
        chain_d.wrap = 1'b0;
        ripple       = advance;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (ripple) begin
                if (chain_q.dig[i] == BCD_TOP) begin
                    chain_d.dig[i] = '0;
                end else begin
                    chain_d.dig[i] = chain_q.dig[i] + 4'd1;
                    ripple         = 1'b0;
                end
            end
        end
        chain_d.wrap = ripple;
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign digits     = chain_q.dig;
    assign wrap_pulse = chain_q.wrap;
endmodule

// File: rtl/tdsc_scan_seq.sv
`timescale 1ns/1ps
// Scan position sequencer: internal divider tick or synchronised external edge.
module tdsc_scan_seq #(
    parameter int SCAN_DIV   = 1000,
    parameter int NUM_DIGITS = 3,
    localparam int DIV_W     = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1,
    localparam int IDX_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             use_ext,
    input  logic             ext_rise,
    output logic [IDX_W-1:0] pos,
    output logic             step_pulse
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [IDX_W-1:0] pos;
        logic             pulse;
    } scan_t;

    scan_t scan_d, scan_q;
    logic  tick, step;

    always_comb begin
        scan_d       = scan_q;
        tick         = (scan_q.div == DIV_W'(SCAN_DIV - 1));
        scan_d.div   = tick ? '0 : scan_q.div + 1'b1;
        step         = use_ext ? ext_rise : tick;
        if (step) begin
            if (scan_q.pos == IDX_W'(NUM_DIGITS - 1)) scan_d.pos = '0;
            else                                      scan_d.pos = scan_q.pos + 1'b1;
        end
        scan_d.pulse = step;
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) scan_q <= '0;
        else     scan_q <= scan_d;
    end

    assign pos        = scan_q.pos;
    assign step_pulse = scan_q.pulse;
endmodule

// File: rtl/tri_decade_scan_counter.sv
`timescale 1ns/1ps
module tri_decade_scan_counter
    import tdsc_pkg::*;
#(
    parameter int SCAN_DIV   = 1000,
    parameter int NUM_DIGITS = 3,
    localparam int IDX_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic                  clk,
    input  logic                  clr,
    input  logic                  count_in,
    input  logic                  count_hold,
    input  logic                  snap,
    input  logic                  scan_sel,
    input  logic                  scan_clk,
    output logic [3:0]            bcd,
    output logic [NUM_DIGITS-1:0] dsel_n,
    output logic                  carry_out,
    output logic                  scan_out
);
    // synchronised bit order: 0 count, 1 hold, 2 snap, 3 scan clock
    logic [3:0] lvl, rise, fall;
    logic       unused_edges;
    logic       advance;

    bcd_t [NUM_DIGITS-1:0] live;
    logic [IDX_W-1:0]      pos;
    logic [IDX_W-1:0]      slot;

    typedef struct packed {
        bcd_t [NUM_DIGITS-1:0] held;
    } hold_t;

    hold_t hold_d, hold_q;

    tdsc_edge_sync #(.WIDTH(4)) u_sync (
        .clk      (clk),
        .clr      (clr),
        .async_in ({scan_clk, snap, count_hold, count_in}),
        .level    (lvl),
        .rise     (rise),
        .fall     (fall)
    );

    assign unused_edges = ^{fall[3:1], rise[0], lvl[3:2]};

    // two advance paths; they need opposite hold levels, so never coincide
    assign advance = (fall[0] & ~lvl[1]) | (rise[1] & lvl[0]);

    tdsc_decade_chain #(.NUM_DIGITS(NUM_DIGITS)) u_chain (
        .clk        (clk),
        .clr        (clr),
        .advance    (advance),
        .digits     (live),
        .wrap_pulse (carry_out)
    );

    tdsc_scan_seq #(.SCAN_DIV(SCAN_DIV), .NUM_DIGITS(NUM_DIGITS)) u_scan (
        .clk        (clk),
        .clr        (clr),
        .use_ext    (scan_sel),
        .ext_rise   (rise[3]),
        .pos        (pos),
        .step_pulse (scan_out)
    );

    always_comb begin
        hold_d = hold_q;
        if (rise[2]) hold_d.held = live;
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) hold_q <= '0;
        else     hold_q <= hold_d;
    end

    // position 0 shows the most significant decade
    always_comb begin
        slot   = IDX_W'(NUM_DIGITS - 1) - pos;
        bcd    = hold_q.held[slot];
        dsel_n = '1;
        if (!clr) dsel_n[pos] = 1'b0;
    end
endmodule

// File: rtl/tdsc_checker.sv
`timescale 1ns/1ps
module tdsc_checker #(
    parameter int NUM_DIGITS = 3
) (
    input logic                  clk,
    input logic                  clr,
    input logic [3:0]            bcd,
    input logic [NUM_DIGITS-1:0] dsel_n,
    input logic                  carry_out,
    input logic                  scan_out
);
    // R5
    one_select_chk: assert property (@(posedge clk) disable iff (clr)
        $countones(~dsel_n) == 1);

    // R1
    bcd_range_chk: assert property (@(posedge clk) disable iff (clr)
        bcd <= 4'd9);

    // R6
    scan_order_chk: assert property (@(posedge clk) disable iff (clr)
        (dsel_n != $past(dsel_n) && $past(dsel_n) != '1) |->
        dsel_n == {$past(dsel_n[NUM_DIGITS-2:0]), $past(dsel_n[NUM_DIGITS-1])});

    // R9
    step_marks_change_chk: assert property (@(posedge clk) disable iff (clr)
        scan_out |-> dsel_n != $past(dsel_n));

    // R9
    change_needs_step_chk: assert property (@(posedge clk) disable iff (clr)
        (dsel_n != $past(dsel_n) && $past(dsel_n) != '1) |-> scan_out);

    // R11
    carry_single_chk: assert property (@(posedge clk) disable iff (clr)
        carry_out |=> !carry_out);

    // R10
    always @(negedge clk) begin
        if (clr === 1'b1) begin
            blank_in_clear_chk: assert (&dsel_n);
        end
    end
endmodule

bind tri_decade_scan_counter tdsc_checker #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
    .clk       (clk),
    .clr       (clr),
    .bcd       (bcd),
    .dsel_n    (dsel_n),
    .carry_out (carry_out),
    .scan_out  (scan_out)
);

// File: tb/tri_decade_scan_counter_tb.sv
`timescale 1ns/1ps
module tri_decade_scan_counter_tb;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       clr, count_in, count_hold, snap, scan_sel, scan_clk;
    logic [3:0] bcd;
    logic [2:0] dsel_n;
    logic       carry_out, scan_out;

    int n_checks    = 0;
    int n_fail      = 0;
    int carry_seen  = 0;
    int scan_pulses = 0;

    always #10 clk = ~clk;

    tri_decade_scan_counter #(.SCAN_DIV(DIV), .NUM_DIGITS(3)) u_dut (
        .clk(clk), .clr(clr), .count_in(count_in), .count_hold(count_hold),
        .snap(snap), .scan_sel(scan_sel), .scan_clk(scan_clk),
        .bcd(bcd), .dsel_n(dsel_n), .carry_out(carry_out), .scan_out(scan_out)
    );

    always @(negedge clk) begin
        if (carry_out === 1'b1) carry_seen++;
        if (scan_out === 1'b1)  scan_pulses++;
    end

    task automatic check(string req, int actual, int expected);
        n_checks++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic adv_by_count();
        count_in = 1'b1; cyc(4);
        count_in = 1'b0; cyc(4);
    endtask

    task automatic do_snap();
        snap = 1'b1; cyc(4);
        snap = 1'b0; cyc(4);
    endtask

    task automatic step_ext();
        scan_clk = 1'b1; cyc(4);
        scan_clk = 1'b0; cyc(4);
    endtask

    // R5: dsel_n bit0 hundreds, bit1 tens, bit2 units
    task automatic read_value(output int v);
        int d0 = 0, d1 = 0, d2 = 0;
        for (int s = 0; s < 3; s++) begin
            step_ext();
            case (dsel_n)
                3'b110: d0 = int'(bcd);
                3'b101: d1 = int'(bcd);
                3'b011: d2 = int'(bcd);
                default: begin
                    n_checks++; n_fail++;
                    $display("FAIL R5: actual select %b expected exactly one low", dsel_n);
                end
            endcase
        end
        v = d0 * 100 + d1 * 10 + d2;
    endtask

    task automatic expect_disp(string req, int expv);
        int v;
        do_snap();
        read_value(v);
        check(req, v, expv);
    endtask

    initial begin
        int exp_cnt;
        int v;
        int last, gap, changes, p0;
        clr = 1'b1; count_in = 0; count_hold = 0; snap = 0; scan_sel = 0; scan_clk = 0;
        cyc(3);
        check("R10 selects blank in clear", int'(dsel_n), 7);
        check("R10 bcd zero in clear", int'(bcd), 0);
        check("R11 no carry in clear", int'(carry_out), 0);
        clr = 1'b0;
        cyc(1);
        check("R6 scan starts on hundreds", int'(dsel_n), 6);
        check("R10 held value zero", int'(bcd), 0);

        // internal scan: R6 order, R7 interval, R9 pulses
        last = int'(dsel_n); gap = 0; changes = 0; p0 = scan_pulses;
        for (int t = 0; t < 200 && changes < 6; t++) begin
            cyc(1); gap++;
            if (int'(dsel_n) != last) begin
                if (changes > 0) check("R7 internal step interval", gap, DIV);
                check("R6 scan order", int'(dsel_n), ((last << 1) & 6) | ((last >> 2) & 1));
                last = int'(dsel_n); gap = 0; changes++;
            end
        end
        cyc(1);
        check("R9 one scan_out pulse per step", scan_pulses - p0, 6);

        // external mode with no scan_clk edges: R8
        scan_sel = 1'b1;
        cyc(2);
        last = int'(dsel_n); p0 = scan_pulses;
        cyc(20);
        check("R8 divider ignored in external mode", int'(dsel_n), last);
        check("R8 no scan_out without external edge", scan_pulses - p0, 0);
        p0 = scan_pulses;
        step_ext();
        check("R8 one step per external edge", scan_pulses - p0, 1);
        check("R6 external step order", int'(dsel_n), ((last << 1) & 6) | ((last >> 2) & 1));

        // count-line advances: R1, R2
        exp_cnt = 0;
        for (int k = 1; k <= 600; k++) begin
            adv_by_count();
            exp_cnt++;
            if (k <= 12 || k == 99 || k == 100 || k == 101 || (k % 97) == 0)
                expect_disp("R1 R2 count-edge sweep", exp_cnt % 1000);
        end
        count_in = 1'b1; cyc(6);
        expect_disp("R2 count rising ignored", exp_cnt);
        count_in = 1'b0; cyc(6); exp_cnt++;
        expect_disp("R2 count falling advances", exp_cnt);
        count_hold = 1'b1; cyc(6);
        expect_disp("R3 hold rising with count low ignored", exp_cnt);
        count_in = 1'b1; cyc(6);
        count_hold = 1'b0; cyc(6);
        expect_disp("R3 hold falling ignored", exp_cnt);

        // hold-line advances with count high: R3, R11
        while (exp_cnt < 1004) begin
            count_hold = 1'b1; cyc(4);
            exp_cnt++;
            if (exp_cnt == 999) check("R11 no carry before wrap", carry_seen, 0);
            if (exp_cnt == 1000) check("R11 carry on 999 to 000", carry_seen, 1);
            if (exp_cnt < 1004) begin
                count_hold = 1'b0; cyc(4);
            end
            if (exp_cnt == 999 || exp_cnt == 1000 || exp_cnt == 1001 || (exp_cnt % 89) == 0)
                expect_disp("R1 R3 hold-edge sweep", exp_cnt % 1000);
        end
        count_in = 1'b0; cyc(6);
        count_hold = 1'b0; cyc(6);
        expect_disp("R2 count falling with hold high ignored", exp_cnt % 1000);

        // R4 held value unchanged until next snapshot
        adv_by_count(); exp_cnt++;
        read_value(v);
        check("R4 display holds without snap", v, (exp_cnt - 1) % 1000);
        expect_disp("R4 snap updates display", exp_cnt % 1000);
        check("R11 exactly one carry overall", carry_seen, 1);

        // R10 mid-run clear
        clr = 1'b1; cyc(2);
        check("R10 blank during clear", int'(dsel_n), 7);
        clr = 1'b0; cyc(1);
        check("R10 scan restarts on hundreds", int'(dsel_n), 6);
        read_value(v);
        check("R10 holding register cleared", v, 0);
        expect_disp("R10 counters cleared", 0);
        check("R11 clear gives no carry", carry_seen, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #3000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule